// File: doc/BRIEF.md
# Serial Receiver with Standby Wakeup

This block turns an asynchronous serial line into data words. It looks for a start bit on a line that is sampled at sixteen times the bit rate, confirms the start bit at its centre, and shifts in the data bits least significant bit first. It then waits for the stop bit and offers the finished word on a valid/ready output. It also watches for an idle line, meaning one full character time of high level after traffic, and raises a flag when it sees one. Either event can drive a single receiver interrupt request, and each source has its own enable.

Software can put the receiver into standby. In standby the interrupt request stays low and received words are thrown away. A select bit sets how standby ends. In address mode it ends with the first character whose top data bit is 1, and that character is delivered. In idle mode it ends with an idle line. In both cases the standby bit then clears itself, so several receivers on a shared line can ignore messages meant for others. The control port is a write strobe with one value per field. Any field can be written at any time, except the receiver enable, which only takes a write while the global interface enable is high.

The output stream gives no back-pressure to the line. The line cannot be stalled. A word that completes while `rd_valid` is still high replaces the held word and `rd_valid` stays high. A word leaves the block only on a cycle where `rd_valid` and `rd_ready` are both high.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset the receiver enable, receive interrupt enable, idle interrupt enable and standby bits read 0, and `rd_valid`, `idle_flag` and `irq` are 0.
- R2: A control write changes the receiver enable (`st_rx_en`) only when `sci_en` is 1. The other control fields take every write.
- R3: A start bit is accepted when the line is still low 8 ticks after the first low sample. Each data bit is then sampled 16 ticks after the previous sample, least significant bit first. One stop-bit sample later the word appears on `rd_data` with `rd_valid` high.
- R4: `rd_valid` stays high until a cycle with `rd_valid` and `rd_ready` both high. A new word arriving while `rd_valid` is high replaces `rd_data`.
- R5: `irq` is high when `rd_valid` is 1 and the receive interrupt enable is 1, provided standby is off. It is low when that enable is 0 and no other source is active.
- R6: After at least one received character, (DATA_BITS+2)×16 consecutive high ticks following the stop-bit sample set `idle_flag`. This happens once per character. `idle_ack` clears the flag.
- R7: `irq` is high when `idle_flag` is 1 and the idle interrupt enable is 1, provided standby is off.
- R8: While the standby bit (`st_wake`) is 1, `irq` is 0.
- R9: With wake select 1 (address mode) in standby, characters whose top data bit is 0 are discarded. The first character whose top data bit is 1 is delivered and clears `st_wake`.
- R10: With wake select 0 (idle mode) in standby, all characters are discarded. A detected idle line clears `st_wake` and does not set `idle_flag`.
- R11: While the receiver enable is 0, no word is received, and `rd_valid`, `rd_data` and `idle_flag` keep their values.
- R12: A low pulse on the line that ends before the start-bit centre sample is ignored and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial receive line, idles high |
| sci_en | input | 1 | Global interface enable; gates writes to the receiver enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rx_en | input | 1 | Receiver enable value to write |
| ctl_rxie | input | 1 | Receive interrupt enable value to write |
| ctl_idleie | input | 1 | Idle interrupt enable value to write |
| ctl_wake | input | 1 | Standby request value to write |
| ctl_wake_sel | input | 1 | Wake method: 1 address mark, 0 idle line |
| idle_ack | input | 1 | Clears the idle flag |
| rd_valid | output | 1 | Receive-full: a word is held |
| rd_ready | input | 1 | Consumer accepts the held word |
| rd_data | output | DATA_BITS | Received word |
| idle_flag | output | 1 | Idle line detected |
| irq | output | 1 | Receiver interrupt request |
| st_rx_en | output | 1 | Current receiver enable |
| st_wake | output | 1 | Current standby bit |

## Verification
If the bit counter or sample phase is off, the first received word comes out shifted or with wrong bits. That shows on `rd_data` one stop bit after the frame, and the queued expected words catch it. If the standby state is wrong, the fault shows in the first character after standby is entered. Either a word leaks out, which the monitor treats as an item it did not expect, or `st_wake` fails to drop after an address mark. If the idle-line counter is wrong, `idle_flag` rises too early or too late compared with a window about one character time after the stop bit. If the arming logic is wrong, the flag rises a second time during a long quiet stretch.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam logic WAKE_ON_ADDR = 1'b1;
  localparam logic WAKE_ON_IDLE = 1'b0;
endpackage

// File: rtl/uart_wake_frame.sv
module uart_wake_frame
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 line_s,
  output logic                 in_hunt,
  output logic                 char_done,
  output logic [DATA_BITS-1:0] char_data
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = OVERSAMPLE / 2;

  rx_state_e             state_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic [DATA_BITS-1:0]  shift_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '1;
        end else begin
          for (int i = 0; i < SYNC_STAGES; i++) begin
            if (i == 0) sync_q[i] <= rxd;
            else        sync_q[i] <= sync_q[i-1];
          end
        end
      end
      assign line_s = sync_q[SYNC_STAGES-1];
    end else begin : g_nosync
      assign line_s = rxd;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else if (!en) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else if (tick) begin
      case (state_q)
        RX_HUNT: begin
          cnt_q <= '0;
          if (!line_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            state_q <= line_s ? RX_HUNT : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(OVERSAMPLE - 1)) begin
            cnt_q   <= '0;
            shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
            if (bit_q == BW'(DATA_BITS - 1)) state_q <= RX_STOP;
            else                             bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(OVERSAMPLE - 1)) begin
            cnt_q   <= '0;
            state_q <= RX_HUNT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign in_hunt   = (state_q == RX_HUNT);
  assign char_done = en && tick && (state_q == RX_STOP) && (cnt_q == CW'(OVERSAMPLE - 1));
  assign char_data = shift_q;
endmodule

// File: rtl/uart_wake_idle.sv
module uart_wake_idle #(
  parameter int IDLE_TICKS = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic in_hunt,
  input  logic line_s,
  input  logic char_done,
  output logic idle_hit
);
  localparam int IW = $clog2(IDLE_TICKS + 1);

  logic [IW-1:0] run_q;
  logic          armed_q;

  assign idle_hit = en && armed_q && tick && in_hunt && line_s &&
                    (run_q == IW'(IDLE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else if (!en) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (char_done)     armed_q <= 1'b1;
      else if (idle_hit) armed_q <= 1'b0;

      if (!in_hunt || !line_s)                   run_q <= '0;
      else if (tick && run_q != IW'(IDLE_TICKS)) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_wake_ctl.sv
module uart_wake_ctl
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sci_en,
  input  logic                 ctl_wr,
  input  logic                 ctl_rx_en,
  input  logic                 ctl_rxie,
  input  logic                 ctl_idleie,
  input  logic                 ctl_wake,
  input  logic                 ctl_wake_sel,
  input  logic                 idle_ack,
  input  logic                 char_done,
  input  logic [DATA_BITS-1:0] char_data,
  input  logic                 idle_hit,
  input  logic                 rd_ready,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 idle_flag,
  output logic                 irq,
  output logic                 rx_en,
  output logic                 wake
);
  logic rxie_q, idleie_q, sel_q;
  logic is_addr, accept, addr_wake, idle_wake;

  assign is_addr   = char_data[DATA_BITS-1];
  assign addr_wake = char_done && wake && (sel_q == WAKE_ON_ADDR) && is_addr;
  assign idle_wake = idle_hit && wake && (sel_q == WAKE_ON_IDLE);
  assign accept    = char_done && (!wake || addr_wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      rxie_q   <= 1'b0;
      idleie_q <= 1'b0;
      wake     <= 1'b0;
      sel_q    <= WAKE_ON_IDLE;
    end else if (ctl_wr) begin
      rxie_q   <= ctl_rxie;
      idleie_q <= ctl_idleie;
      wake     <= ctl_wake;
      sel_q    <= ctl_wake_sel;
      if (sci_en) rx_en <= ctl_rx_en;
    end else if (addr_wake || idle_wake) begin
      wake <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      idle_flag <= 1'b0;
    end else begin
      if (accept) begin
        rd_valid <= 1'b1;
        rd_data  <= char_data;
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
      end

      if (idle_hit && !wake) idle_flag <= 1'b1;
      else if (idle_ack)     idle_flag <= 1'b0;
    end
  end

  assign irq = !wake && ((rd_valid && rxie_q) || (idle_flag && idleie_q));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic                 sci_en,
  input  logic                 ctl_wr,
  input  logic                 ctl_rx_en,
  input  logic                 ctl_rxie,
  input  logic                 ctl_idleie,
  input  logic                 ctl_wake,
  input  logic                 ctl_wake_sel,
  input  logic                 idle_ack,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 idle_flag,
  output logic                 irq,
  output logic                 st_rx_en,
  output logic                 st_wake
);
  localparam int IDLE_TICKS = (DATA_BITS + 2) * OVERSAMPLE;

  logic                 line_s, in_hunt, char_done, idle_hit;
  logic [DATA_BITS-1:0] char_data;

  uart_wake_frame #(
    .DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .en(st_rx_en), .tick(tick16), .rxd(rxd),
    .line_s(line_s), .in_hunt(in_hunt), .char_done(char_done), .char_data(char_data)
  );

  uart_wake_idle #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(st_rx_en), .tick(tick16), .in_hunt(in_hunt),
    .line_s(line_s), .char_done(char_done), .idle_hit(idle_hit)
  );

  uart_wake_ctl #(.DATA_BITS(DATA_BITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sci_en(sci_en), .ctl_wr(ctl_wr),
    .ctl_rx_en(ctl_rx_en), .ctl_rxie(ctl_rxie), .ctl_idleie(ctl_idleie),
    .ctl_wake(ctl_wake), .ctl_wake_sel(ctl_wake_sel), .idle_ack(idle_ack),
    .char_done(char_done), .char_data(char_data), .idle_hit(idle_hit),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .idle_flag(idle_flag), .irq(irq), .rx_en(st_rx_en), .wake(st_wake)
  );
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic sci_en,
  input logic ctl_wr,
  input logic rd_valid,
  input logic rd_ready,
  input logic idle_flag,
  input logic irq,
  input logic st_rx_en,
  input logic st_wake,
  input logic char_done,
  input logic idle_hit
);
  AST_STANDBY_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    st_wake |-> !irq); // R8

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid); // R4

  AST_RXEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_en |=> (st_rx_en == $past(st_rx_en))); // R2

  AST_DISABLED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rx_en && !rd_valid) |=> !rd_valid); // R11

  AST_STANDBY_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wake && !idle_flag) |=> !idle_flag); // R10

  AST_WAKE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_wake) && !$past(ctl_wr)) |-> ($past(char_done) || $past(idle_hit))); // R9
endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sci_en(sci_en), .ctl_wr(ctl_wr),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .idle_flag(idle_flag), .irq(irq),
  .st_rx_en(st_rx_en), .st_wake(st_wake), .char_done(char_done), .idle_hit(idle_hit)
);

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic       sci_en = 1'b0;
  logic       ctl_wr = 1'b0, ctl_rx_en = 1'b0, ctl_rxie = 1'b0, ctl_idleie = 1'b0;
  logic       ctl_wake = 1'b0, ctl_wake_sel = 1'b0, idle_ack = 1'b0;
  logic       rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       idle_flag, irq, st_rx_en, st_wake;

  int checks = 0;
  int failures = 0;
  bit auto_pop = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  uart_wake_rx u_uart_wake_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .sci_en(sci_en),
    .ctl_wr(ctl_wr), .ctl_rx_en(ctl_rx_en), .ctl_rxie(ctl_rxie),
    .ctl_idleie(ctl_idleie), .ctl_wake(ctl_wake), .ctl_wake_sel(ctl_wake_sel),
    .idle_ack(idle_ack), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .idle_flag(idle_flag), .irq(irq),
    .st_rx_en(st_rx_en), .st_wake(st_wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic ie, input logic iie,
                        input logic wk, input logic sel);
    @(negedge clk);
    ctl_rx_en = en; ctl_rxie = ie; ctl_idleie = iie; ctl_wake = wk; ctl_wake_sel = sel;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic ack_idle();
    @(negedge clk); idle_ack = 1'b1;
    @(negedge clk); idle_ack = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one frame, 16 clocks per bit; pushes the word if it should arrive
  task automatic send_char(input logic [7:0] b, input bit expect_out);
    if (expect_out) exp_q.push_back(b);
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // monitor: pops each delivered word and compares it with the queue (R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ready) begin
        rd_ready = 1'b0;
      end else if (auto_pop && rd_valid) begin
        if (exp_q.size() == 0) chk("R3 unexpected word", {24'h0, rd_data}, 32'hFFFF_FFFF);
        else chk("R3 word", {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
        rd_ready = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(2);
    // R1 reset state
    chk("R1 rx_en", st_rx_en, 0);
    chk("R1 wake", st_wake, 0);
    chk("R1 valid/idle/irq", {rd_valid, idle_flag, irq}, 0);

    // R2 receiver enable locked while sci_en low
    wr_ctl(1, 0, 0, 0, 0);
    chk("R2 locked", st_rx_en, 0);
    sci_en = 1'b1;
    wr_ctl(1, 0, 0, 0, 0);
    chk("R2 written", st_rx_en, 1);

    // R3 several patterns through the scoreboard
    auto_pop = 1'b1;
    send_char(8'h5A, 1);
    send_char(8'hA3, 1);
    send_char(8'h01, 1);
    send_char(8'h80, 1);
    idle_cycles(20);
    chk("R3 drained", exp_q.size(), 0);

    // R4 overwrite while full, R5 irq from full
    auto_pop = 1'b0;
    send_char(8'h11, 0);
    send_char(8'h22, 1);
    idle_cycles(10);
    chk("R4 valid", rd_valid, 1);
    chk("R4 overwrite data", rd_data, 8'h22);
    chk("R5 irq off", irq, 0);
    wr_ctl(1, 1, 0, 0, 0);
    chk("R5 irq on", irq, 1);

    // R8 standby masks irq, R9 address wake
    wr_ctl(1, 1, 0, 1, 1);
    chk("R8 masked", irq, 0);
    auto_pop = 1'b1;
    idle_cycles(5);
    chk("R4 popped", rd_valid, 0);
    send_char(8'h12, 0);
    idle_cycles(10);
    chk("R9 discard", {rd_valid, st_wake}, 2'b01);
    auto_pop = 1'b0;
    send_char(8'h85, 1);
    idle_cycles(10);
    chk("R9 woke", {rd_valid, st_wake, irq}, 3'b101);
    chk("R9 data", rd_data, 8'h85);
    auto_pop = 1'b1;
    idle_cycles(200);
    ack_idle();

    // R6 idle detection, R7 idle irq
    wr_ctl(1, 0, 0, 0, 0);
    send_char(8'h33, 1);
    idle_cycles(100);
    chk("R6 not yet", idle_flag, 0);
    idle_cycles(100);
    chk("R6 idle set", idle_flag, 1);
    chk("R7 irq off", irq, 0);
    wr_ctl(1, 0, 1, 0, 0);
    chk("R7 irq on", irq, 1);
    ack_idle();
    chk("R6 ack", idle_flag, 0);
    idle_cycles(400);
    chk("R6 once", idle_flag, 0);

    // R10 idle-line wake
    wr_ctl(1, 0, 1, 1, 0);
    send_char(8'h99, 0);
    idle_cycles(40);
    chk("R10 discard", {rd_valid, st_wake}, 2'b01);
    idle_cycles(200);
    chk("R10 woke", {st_wake, idle_flag, irq}, 3'b000);

    // R11 disable keeps flags
    auto_pop = 1'b0;
    wr_ctl(1, 0, 0, 0, 0);
    send_char(8'h44, 1);
    idle_cycles(200);
    chk("R11 before", {rd_valid, idle_flag}, 2'b11);
    wr_ctl(0, 0, 0, 0, 0);
    chk("R11 flags kept", {rd_valid, idle_flag}, 2'b11);
    send_char(8'h55, 0);
    idle_cycles(200);
    chk("R11 data kept", {rd_valid, idle_flag, rd_data}, {2'b11, 8'h44});
    wr_ctl(1, 0, 0, 0, 0);
    auto_pop = 1'b1;
    idle_cycles(10);

    // R12 glitch shorter than half a bit
    @(negedge clk); rxd = 1'b0;
    idle_cycles(4);
    rxd = 1'b1;
    idle_cycles(300);
    chk("R12 no word", rd_valid, 0);
    chk("R3 queue empty", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule